// File: doc/BRIEF.md
# Serial ADC acquisition adapter

This block sits between a serial 8-bit successive-approximation converter and the logic that consumes its samples. It gives the rest of the design a parallel sample source. A low-to-high transition on the sample request input starts one acquisition.

The adapter then does the following, in order:
- It drives the converter's conversion-start line high for a short pulse.
- It waits a fixed number of system clock cycles while the converter runs its internal approximation, which takes roughly 4 µs.
- It issues exactly eight serial clock pulses and captures the result most significant bit first.
- It presents the byte on a parallel output together with a one-cycle valid pulse.

The result is straight binary, so one LSB corresponds to the reference voltage divided by 256.

The start-pulse length, the conversion wait and the half-period of the serial clock are parameters counted in system clock cycles. Together they fix the length of one acquisition, which must fit inside a 5.4 µs sampling period. That period allows about 185 k samples per second. With the default values at 100 MHz, one acquisition takes 4.67 µs from request edge to valid. A request edge that arrives while an acquisition is in progress is ignored. A request held high does not start a second acquisition.

Top module: `adc_serial_capture`

## Requirements
- R1: While reset is asserted, and until the first request edge after it, `adc_cnv`, `adc_sck` and `smp_valid` are low and `smp_data` is 0.
- R2: A request edge that is seen while idle drives `adc_cnv` high for exactly CNV_LEN cycles, starting in the cycle after the edge is sampled. There is one conversion-start pulse per acquisition.
- R3: After `adc_cnv` falls, `adc_sck` stays low for exactly CONV_WAIT + SCK_HALF cycles before its first rising edge. It never rises while `adc_cnv` is high.
- R4: Each acquisition issues exactly DATA_W rising edges on `adc_sck`. Each high phase lasts SCK_HALF cycles and each low phase lasts SCK_HALF cycles. The clock idles low outside the readout.
- R5: `adc_dout` is sampled at each rising edge of `adc_sck`, with the first bit taken as the MSB. The converter is expected to change `adc_dout` only after a falling edge of `adc_sck`. `smp_data` equals the converter's straight-binary code.
- R6: `smp_valid` is high for exactly one cycle per acquisition. Counting the edge that samples the request as edge 0, the edge that sets `smp_valid` is edge CNV_LEN + CONV_WAIT + 2·SCK_HALF·DATA_W.
- R7: `smp_data` changes only in the cycle in which `smp_valid` is high and holds its value otherwise.
- R8: A low-to-high request transition during an acquisition starts no new conversion. It does not change the result or add a valid pulse.
- R9: A request level that stays high starts only one acquisition. A new acquisition needs the request to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_req | input | 1 | Sample request; a rising transition starts an acquisition |
| adc_dout | input | 1 | Serial result bit from the converter |
| adc_cnv | output | 1 | Conversion-start pulse to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| smp_data | output | DATA_W | Last captured sample, straight binary |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions assume that the request input is synchronous to the system clock and low while reset is asserted. They also assume that the converter changes its serial bit only after a falling serial clock edge or at the start of a conversion, so the value sampled at a rising edge is settled. The bench's converter model follows exactly that rule: it loads its code when the start pulse rises and steps to the next bit on each falling serial clock. The bench drives the request only on falling system clock edges. Requests issued mid-acquisition are placed in the start, wait and readout phases so that each phase is covered.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2,
    ST_READ  = 2'd3
  } acq_state_t;

  // bits needed to count 0 .. n-1
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // busy cycles of one acquisition: start pulse + wait + readout
  function automatic int acq_cycles(input int cnv_len, input int conv_wait,
                                    input int sck_half, input int nbits);
    return cnv_len + conv_wait + 2 * sck_half * nbits;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNV_LEN   = 2,
  parameter int CONV_WAIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic bit_end,
  output logic cnv_on,
  output logic read_on,
  output logic busy,
  output logic done_evt
);
  localparam int MAXC = (CNV_LEN > CONV_WAIT) ? CNV_LEN : CONV_WAIT;
  localparam int CW   = cnt_bits(MAXC);
  localparam int BW   = cnt_bits(DATA_W);
  localparam logic [CW-1:0] CNV_LAST  = CW'(CNV_LEN - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(CONV_WAIT - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

  acq_state_t st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic last_bit;

  assign last_bit = (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_evt) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
        end
        ST_START: begin
          if (cnt_q == CNV_LAST) begin
            st_q  <= ST_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_q == WAIT_LAST) begin
            st_q  <= ST_READ;
            cnt_q <= '0;
            bit_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_READ: begin
          if (bit_end) begin
            if (last_bit) st_q <= ST_IDLE;
            else          bit_q <= bit_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_on   = (st_q == ST_START);
  assign read_on  = (st_q == ST_READ);
  assign busy     = (st_q != ST_IDLE);
  assign done_evt = read_on && bit_end && last_bit;

endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen
  import adc_cap_pkg::*;
#(
  parameter int SCK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic smp_stb,
  output logic bit_end
);
  localparam int PW = cnt_bits(2 * SCK_HALF);
  localparam logic [PW-1:0] PH_RISE = PW'(SCK_HALF);
  localparam logic [PW-1:0] PH_SMP  = PW'(SCK_HALF - 1);
  localparam logic [PW-1:0] PH_END  = PW'(2 * SCK_HALF - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ph_q <= '0;
    else if (ph_q == PH_END) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  // low for SCK_HALF cycles, then high for SCK_HALF cycles
  assign sck     = run && (ph_q >= PH_RISE);
  // the edge that raises sck also captures the data bit
  assign smp_stb = run && (ph_q == PH_SMP);
  assign bit_end = run && (ph_q == PH_END);

endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              din,
  input  logic              done_evt,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (smp_stb) sr_q <= {sr_q[DATA_W-2:0], din};
      if (done_evt) data_q <= sr_q;
      valid_q <= done_evt;
    end
  end

endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture #(
  parameter int DATA_W    = 8,
  parameter int CNV_LEN   = 2,
  parameter int CONV_WAIT = 400,
  parameter int SCK_HALF  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_req,
  input  logic              adc_dout,
  output logic              adc_cnv,
  output logic              adc_sck,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_valid
);
  logic req_d;
  logic req_rise;
  logic start_evt;
  logic busy;
  logic read_on;
  logic smp_stb;
  logic bit_end;
  logic done_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= smp_req;
  end

  assign req_rise  = smp_req && !req_d;
  assign start_evt = req_rise && !busy;

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .CNV_LEN(CNV_LEN), .CONV_WAIT(CONV_WAIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .bit_end(bit_end),
    .cnv_on(adc_cnv), .read_on(read_on), .busy(busy), .done_evt(done_evt)
  );

  adc_sck_gen #(
    .SCK_HALF(SCK_HALF)
  ) u_sck (
    .clk(clk), .rst_n(rst_n), .run(read_on),
    .sck(adc_sck), .smp_stb(smp_stb), .bit_end(bit_end)
  );

  adc_shift_in #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .din(adc_dout),
    .done_evt(done_evt), .data_q(smp_data), .valid_q(smp_valid)
  );

endmodule

// File: rtl/adc_serial_capture_chk.sv
module adc_serial_capture_chk
  import adc_cap_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNV_LEN   = 2,
  parameter int CONV_WAIT = 400,
  parameter int SCK_HALF  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_req,
  input logic              adc_cnv,
  input logic              adc_sck,
  input logic [DATA_W-1:0] smp_data,
  input logic              smp_valid,
  input logic              busy,
  input logic              smp_stb
);
  localparam int ACQ = acq_cycles(CNV_LEN, CONV_WAIT, SCK_HALF, DATA_W);
  localparam int LW  = $clog2(ACQ + 1) + 1;
  localparam int GW  = $clog2(CONV_WAIT + 1) + 1;
  localparam int SW  = $clog2(DATA_W + 1) + 1;

  logic [LW-1:0] len_q;
  logic [GW-1:0] gap_q;
  logic [SW-1:0] stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      gap_q <= '0;
      stb_q <= '0;
    end else begin
      len_q <= busy ? len_q + 1'b1 : '0;
      if (adc_cnv) gap_q <= '0;
      else if (gap_q < GW'(CONV_WAIT)) gap_q <= gap_q + 1'b1;
      if (adc_cnv) stb_q <= '0;
      else if (smp_stb) stb_q <= stb_q + 1'b1;
    end
  end

  AST_CNV_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv |-> busy); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_sck); // R4
  AST_SCK_NOT_IN_CNV: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sck |-> !adc_cnv); // R3
  AST_WAIT_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && stb_q == '0) |-> (gap_q >= GW'(CONV_WAIT))); // R3
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (stb_q == SW'(DATA_W))); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R6
  AST_ACQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (len_q == LW'(ACQ))); // R6
  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> smp_valid); // R6
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$rose(adc_cnv)); // R8
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(smp_req)); // R9

endmodule

bind adc_serial_capture adc_serial_capture_chk #(
  .DATA_W(DATA_W), .CNV_LEN(CNV_LEN), .CONV_WAIT(CONV_WAIT), .SCK_HALF(SCK_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .adc_cnv(adc_cnv),
  .adc_sck(adc_sck), .smp_data(smp_data), .smp_valid(smp_valid),
  .busy(busy), .smp_stb(smp_stb)
);

// File: tb/adc_serial_capture_tb.sv
module adc_serial_capture_tb;
  localparam int W   = 8;
  localparam int CL  = 2;
  localparam int CWT = 40;
  localparam int HF  = 2;
  localparam int LAT = 1 + CL + CWT + 2 * HF * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_req = 1'b0;
  logic adc_dout = 1'b0;
  logic adc_cnv, adc_sck, smp_valid;
  logic [W-1:0] smp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adc_serial_capture #(
    .DATA_W(W), .CNV_LEN(CL), .CONV_WAIT(CWT), .SCK_HALF(HF)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_req(smp_req), .adc_dout(adc_dout),
    .adc_cnv(adc_cnv), .adc_sck(adc_sck), .smp_data(smp_data), .smp_valid(smp_valid)
  );

  // behavioural converter: code latched at start, MSB first, steps on falling sck
  logic [W-1:0] ana_code = '0;
  logic [W-1:0] held = '0;
  int bidx = W - 1;
  always @(posedge adc_cnv or negedge adc_sck) begin
    if (adc_cnv) begin
      held = ana_code;
      bidx = W - 1;
      adc_dout = ana_code[W-1];
    end else begin
      if (bidx > 0) bidx = bidx - 1;
      adc_dout = held[bidx];
    end
  end

  // port monitor, sampled on falling clock edges
  logic clr = 1'b0;
  logic p_cnv = 1'b0, p_sck = 1'b0;
  int cnv_rises, cnv_hi, sck_rises, sck_hi, gap, valid_cnt;
  logic gap_seen;
  always @(negedge clk) begin
    if (clr) begin
      cnv_rises = 0; cnv_hi = 0; sck_rises = 0; sck_hi = 0;
      gap = 0; gap_seen = 1'b0; valid_cnt = 0;
    end else begin
      if (adc_cnv && !p_cnv) cnv_rises++;
      if (adc_cnv) cnv_hi++;
      if (adc_sck && !p_sck) sck_rises++;
      if (adc_sck) sck_hi++;
      if (smp_valid) valid_cnt++;
      if (adc_cnv) begin gap = 0; gap_seen = 1'b0; end
      else if (!gap_seen) begin
        if (adc_sck) gap_seen = 1'b1; else gap++;
      end
    end
    p_cnv = adc_cnv;
    p_sck = adc_sck;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 clr = 1'b1;
    @(negedge clk); #1 clr = 1'b0;
  endtask

  task automatic run_acq(input logic [W-1:0] code, output logic [W-1:0] got, output int lat);
    ana_code = code;
    clear_mon();
    @(negedge clk) smp_req = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!smp_valid && lat < 4 * LAT);
    got = smp_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    int lat;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!adc_cnv && !adc_sck && !smp_valid, "R1 ctrl idle in reset",
          {adc_cnv, adc_sck, smp_valid}, 0);
    check(smp_data == '0, "R1 data in reset", smp_data, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!adc_cnv && !adc_sck && !smp_valid && smp_data == '0, "R1 idle after reset",
          {smp_data, adc_cnv, adc_sck, smp_valid}, 0);

    // exhaustive sweep of all codes
    for (int c = 0; c < (1 << W); c++) begin
      run_acq(W'(c), got, lat);
      check(lat == LAT, "R6 latency", lat, LAT);
      check(got == W'(c), "R5 captured code", got, c);
      check(cnv_rises == 1 && cnv_hi == CL, "R2 start pulse", cnv_hi, CL);
      check(gap == CWT + HF, "R3 wait before sck", gap, CWT + HF);
      check(sck_rises == W, "R4 sck edges", sck_rises, W);
      check(sck_hi == W * HF, "R4 sck high cycles", sck_hi, W * HF);
      @(negedge clk);
      check(!smp_valid, "R6 valid one cycle", smp_valid, 0);
      smp_req = 1'b0;
      repeat (3) @(negedge clk);
      check(smp_data == W'(c) && valid_cnt == 1, "R7 data holds", smp_data, c);
    end

    // R9: request held high does not retrigger
    run_acq(8'hA5, got, lat);
    check(got == 8'hA5, "R9 first acquisition", got, 8'hA5);
    ana_code = 8'h3C;
    clear_mon();
    repeat (2 * LAT) @(negedge clk);
    check(cnv_rises == 0 && valid_cnt == 0, "R9 held level no restart",
          cnv_rises + valid_cnt, 0);
    check(smp_data == 8'hA5, "R9 data unchanged", smp_data, 8'hA5);
    smp_req = 1'b0;
    @(negedge clk);
    run_acq(8'h3C, got, lat);
    check(got == 8'h3C && lat == LAT, "R9 fresh edge restarts", got, 8'h3C);
    @(negedge clk) smp_req = 1'b0;

    // R8: edges during start, wait and readout are ignored
    ana_code = 8'h96;
    clear_mon();
    @(negedge clk) smp_req = 1'b1;
    @(negedge clk) smp_req = 1'b0;
    @(negedge clk) smp_req = 1'b1;
    ana_code = 8'h11;
    repeat (3) @(negedge clk);
    smp_req = 1'b0;
    repeat (10) @(negedge clk);
    smp_req = 1'b1;
    repeat (CL + CWT) @(negedge clk);
    smp_req = 1'b0;
    @(negedge clk) smp_req = 1'b1;
    @(negedge clk) smp_req = 1'b0;
    repeat (2 * LAT) @(negedge clk);
    check(cnv_rises == 1, "R8 single conversion", cnv_rises, 1);
    check(valid_cnt == 1, "R8 single valid", valid_cnt, 1);
    check(smp_data == 8'h96, "R8 first code kept", smp_data, 8'h96);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule